// File: doc/BRIEF.md
# Flash Program/Erase Error-Protection Controller

This block sits beside an on-chip flash array and polices what the CPU does while a program or erase operation runs. It keeps a status register whose top bit is a sticky error flag. The flag is set when the CPU does something that is not allowed during program or erase. Once set, the flag keeps the array in an error-protected state until the chip is reset or enters hardware standby. The flash cell timing and the CPU itself are outside this block.

It also holds two erase-select registers, each eight bits wide. Each bit picks one flash block for erasure. Both registers are wiped whenever the flash is not writable, or when a reset or standby occurs. Software reaches the registers through a single-cycle synchronous bus with an address, a write strobe and 8-bit data. The read data is combinational.

The protect output combines the error flag with the write-enable pin. The per-block erase enables reach the array only when protect is low and exactly one erase-select bit, or none, is set across both registers.

Top module: `flash_pe_guard`

## Requirements
- R1: Address 0 reads the status register, with the error flag in bit 7 and bits 6..0 always 0. Address 1 reads the first erase-select register, address 2 the second, and address 3 reads 0x00.
- R2: A flash read (`rd_flash_i`) while `pe_active_i` is high sets the error flag at the next clock edge. This covers instruction fetches and vector reads. A read with `rd_overlap_i` high (RAM overlapping flash space) does not set it, and neither does a read while idle.
- R3: An exception start during program/erase sets the flag when `exc_kind_i` is 4..7. Codes 0 (reset), 1 (illegal instruction), 2 (trap) and 3 (divide-by-zero) leave it unchanged.
- R4: A sleep or software-standby entry (`sleep_i`), or a bus release (`bus_rel_i`), during program/erase sets the flag.
- R5: The flag is sticky. Only a low `rst_n`, `wdog_rst_i` or `hw_stby_i` clears it, and clearing wins over setting in the same cycle. Software standby and the write-enable pin leave it unchanged.
- R6: Both erase-select registers are read/write and reset to 0x00. Bit b of register k drives `erase_en_o[8*k+b]`.
- R7: Both erase-select registers are forced to 0x00 in the cycle after any of these is high: `hw_stby_i`, `sw_stby_i`, `wdog_rst_i`, `wen_pin_i` low, or `swe_i` low. Writes in that cycle are ignored.
- R8: When more than one bit is set across both erase-select registers, `multi_sel_o` is 1 and all erase enables are 0.
- R9: `protect_o` equals the error flag OR NOT `wen_pin_i`. While it is 1, all erase enables are 0.
- R10: Writes to address 0 are ignored, so software can neither set nor clear the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low pin reset |
| wdog_rst_i | input | 1 | Watchdog reset request, synchronous |
| hw_stby_i | input | 1 | Hardware standby entry |
| sw_stby_i | input | 1 | Software standby entry |
| wen_pin_i | input | 1 | Flash write-enable pin level |
| swe_i | input | 1 | Software write-enable bit |
| pe_active_i | input | 1 | A program or erase operation is in progress |
| rd_flash_i | input | 1 | Read strobe into flash address space |
| rd_overlap_i | input | 1 | The current read targets RAM overlapping flash space |
| exc_start_i | input | 1 | Exception handling begins |
| exc_kind_i | input | 3 | Exception class code (0 reset, 1 illegal, 2 trap, 3 divide, 4..7 others) |
| sleep_i | input | 1 | Sleep or software-standby instruction executes |
| bus_rel_i | input | 1 | Bus released to an external master |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| erase_en_o | output | 16 | Per-block erase enables to the array |
| protect_o | output | 1 | Program/erase protected |
| multi_sel_o | output | 1 | More than one erase-select bit set |

## Verification
The checker evaluates several rules on every clock. It confirms that erase enables are never more than one-hot and never active under protect. It confirms that a forbidden read, sleep or bus release during program/erase leaves protect high on the next cycle, and that a set flag stays set unless a clearing input is present. It also confirms that the erase-select wipe conditions empty the enables and that the status low bits read as zero. Other properties only the bench scenarios can show: that each excluded exception code and the overlap read leave the flag clear, that status writes are ignored, that register values read back, and that the violation output tracks multi-bit selections across both registers.

// File: rtl/fpg_pkg.sv
// Shared definitions for the flash program/erase guard.
// Assumes a 3-bit exception class code supplied by the CPU core.
package fpg_pkg;
    typedef enum logic [2:0] {
        EXC_RESET   = 3'd0,
        EXC_ILLEGAL = 3'd1,
        EXC_TRAP    = 3'd2,
        EXC_DIVZERO = 3'd3,
        EXC_IRQ     = 3'd4,
        EXC_NMI     = 3'd5,
        EXC_MISC6   = 3'd6,
        EXC_MISC7   = 3'd7
    } exc_kind_t;

    // True when an exception of this class counts as a forbidden event.
    function automatic logic exc_is_forbidden(input logic [2:0] kind);
        return !(kind == EXC_RESET || kind == EXC_ILLEGAL ||
                 kind == EXC_TRAP  || kind == EXC_DIVZERO);
    endfunction
endpackage

// File: rtl/fpg_err_latch.sv
// Sticky error flag. Assumes all event strobes are synchronous single-cycle
// pulses. A clear request takes priority over any set event.
module fpg_err_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       pe_active_i,
    input  logic       rd_flash_i,
    input  logic       rd_overlap_i,
    input  logic       exc_start_i,
    input  logic [2:0] exc_kind_i,
    input  logic       sleep_i,
    input  logic       bus_rel_i,
    output logic       err_o
);
    logic set_evt;

    // Collect the forbidden events seen while program/erase is running.
    always_comb begin
        set_evt = pe_active_i &&
                  ((rd_flash_i && !rd_overlap_i) ||
                   (exc_start_i && fpg_pkg::exc_is_forbidden(exc_kind_i)) ||
                   sleep_i || bus_rel_i);
    end

    // Hold the flag until a reset-class clear arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_o <= 1'b0;
        else if (clr_i)   err_o <= 1'b0;
        else if (set_evt) err_o <= 1'b1;
    end
endmodule

// File: rtl/fpg_erase_bank.sv
// One erase-select register. Assumes force_clr_i already merges every
// condition under which the flash must not be erasable.
module fpg_erase_bank #(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_clr_i,
    input  logic             wr_en_i,
    input  logic [BLK_W-1:0] wdata_i,
    output logic [BLK_W-1:0] q_o
);
    // Store software writes unless a wipe condition is present.
    always_ff @(posedge clk) begin
        if (!rst_n)           q_o <= '0;
        else if (force_clr_i) q_o <= '0;
        else if (wr_en_i)     q_o <= wdata_i;
    end
endmodule

// File: rtl/fpg_select_gate.sv
// Qualifies the merged erase selection. Assumes at most one bit may be set.
// Anything more is flagged and fully suppressed rather than arbitrated.
module fpg_select_gate #(
    parameter int N = 16
) (
    input  logic [N-1:0] sel_i,
    input  logic         protect_i,
    output logic [N-1:0] en_o,
    output logic         multi_o
);
    localparam int CNT_W = $clog2(N + 1);
    logic [CNT_W-1:0] ones;

    // Count selected blocks and gate the enables.
    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) ones = ones + CNT_W'(sel_i[i]);
        multi_o = (ones > CNT_W'(1));
        en_o    = (protect_i || multi_o) ? '0 : sel_i;
    end
endmodule

// File: rtl/flash_pe_guard.sv
// Top of the flash program/erase guard: register decode, sticky error flag,
// erase-select banks and output gating. Assumes a single-cycle synchronous
// register bus with combinational read data.
module flash_pe_guard #(
    parameter int BLK_W     = 8,
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wdog_rst_i,
    input  logic                       hw_stby_i,
    input  logic                       sw_stby_i,
    input  logic                       wen_pin_i,
    input  logic                       swe_i,
    input  logic                       pe_active_i,
    input  logic                       rd_flash_i,
    input  logic                       rd_overlap_i,
    input  logic                       exc_start_i,
    input  logic [2:0]                 exc_kind_i,
    input  logic                       sleep_i,
    input  logic                       bus_rel_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       wr_i,
    input  logic [BLK_W-1:0]           wdata_i,
    output logic [BLK_W-1:0]           rdata_o,
    output logic [NUM_BANKS*BLK_W-1:0] erase_en_o,
    output logic                       protect_o,
    output logic                       multi_sel_o
);
    localparam int SEL_W = NUM_BANKS * BLK_W;

    logic                 err_q;
    logic                 err_clr;
    logic                 bank_clr;
    logic [SEL_W-1:0]     sel_all;
    logic [BLK_W-1:0]     bank_q [NUM_BANKS];

    // Reset-class clears for the flag; wider wipe set for the banks.
    always_comb begin
        err_clr   = wdog_rst_i || hw_stby_i;
        bank_clr  = err_clr || sw_stby_i || !wen_pin_i || !swe_i;
        protect_o = err_q || !wen_pin_i;
    end

    fpg_err_latch u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (err_clr),
        .pe_active_i  (pe_active_i),
        .rd_flash_i   (rd_flash_i),
        .rd_overlap_i (rd_overlap_i),
        .exc_start_i  (exc_start_i),
        .exc_kind_i   (exc_kind_i),
        .sleep_i      (sleep_i),
        .bus_rel_i    (bus_rel_i),
        .err_o        (err_q)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        fpg_erase_bank #(.BLK_W(BLK_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .force_clr_i (bank_clr),
            .wr_en_i     (wr_i && (addr_i == ADDR_W'(k + 1))),
            .wdata_i     (wdata_i),
            .q_o         (bank_q[k])
        );
        assign sel_all[k*BLK_W +: BLK_W] = bank_q[k];
    end

    fpg_select_gate #(.N(SEL_W)) u_gate (
        .sel_i     (sel_all),
        .protect_i (protect_o),
        .en_o      (erase_en_o),
        .multi_o   (multi_sel_o)
    );

    // Read mux: status at 0, banks from 1 upward, zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (addr_i == '0) rdata_o[BLK_W-1] = err_q;
        for (int k = 0; k < NUM_BANKS; k++)
            if (addr_i == ADDR_W'(k + 1)) rdata_o = bank_q[k];
    end
endmodule

// File: rtl/fpg_checker.sv
// Concurrent checks on the guard's ports, bound to every instance of the top.
module fpg_checker #(
    parameter int BLK_W     = 8,
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wdog_rst_i,
    input logic                       hw_stby_i,
    input logic                       sw_stby_i,
    input logic                       wen_pin_i,
    input logic                       swe_i,
    input logic                       pe_active_i,
    input logic                       rd_flash_i,
    input logic                       rd_overlap_i,
    input logic                       sleep_i,
    input logic                       bus_rel_i,
    input logic [ADDR_W-1:0]          addr_i,
    input logic [BLK_W-1:0]           rdata_o,
    input logic [NUM_BANKS*BLK_W-1:0] erase_en_o,
    input logic                       protect_o
);
    logic no_clr;
    assign no_clr = !wdog_rst_i && !hw_stby_i;

    a_r8_single_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(erase_en_o) <= 1);

    a_r9_protect_gates: assert property (@(posedge clk) disable iff (!rst_n)
        protect_o |-> (erase_en_o == '0));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (protect_o && wen_pin_i && no_clr) |=> protect_o);

    a_r2_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_active_i && rd_flash_i && !rd_overlap_i && no_clr) |=> protect_o);

    a_r4_sleep_bus_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_active_i && (sleep_i || bus_rel_i) && no_clr) |=> protect_o);

    a_r7_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        (!wen_pin_i || !swe_i || sw_stby_i || hw_stby_i || wdog_rst_i)
        |=> (erase_en_o == '0));

    a_r1_status_low: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == '0) |-> (rdata_o[BLK_W-2:0] == '0));
endmodule

bind flash_pe_guard fpg_checker #(
    .BLK_W(BLK_W), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wdog_rst_i(wdog_rst_i), .hw_stby_i(hw_stby_i),
    .sw_stby_i(sw_stby_i), .wen_pin_i(wen_pin_i), .swe_i(swe_i),
    .pe_active_i(pe_active_i), .rd_flash_i(rd_flash_i),
    .rd_overlap_i(rd_overlap_i), .sleep_i(sleep_i), .bus_rel_i(bus_rel_i),
    .addr_i(addr_i), .rdata_o(rdata_o), .erase_en_o(erase_en_o),
    .protect_o(protect_o)
);

// File: tb/sim_flash_pe_guard.sv
`timescale 1ns/1ps
module sim_flash_pe_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdog_rst_i = 0, hw_stby_i = 0, sw_stby_i = 0;
    logic wen_pin_i = 0, swe_i = 0, pe_active_i = 0;
    logic rd_flash_i = 0, rd_overlap_i = 0, exc_start_i = 0;
    logic [2:0] exc_kind_i = 0;
    logic sleep_i = 0, bus_rel_i = 0;
    logic [1:0] addr_i = 0;
    logic wr_i = 0;
    logic [7:0] wdata_i = 0;
    logic [7:0] rdata_o;
    logic [15:0] erase_en_o;
    logic protect_o, multi_sel_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    // Behavioural reference state
    bit m_err = 0;
    int m_bank [2] = '{0, 0};

    flash_pe_guard u0 (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
        end
    endtask

    // Reference update at each rising edge using the inputs held since the falling edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_err = 0; m_bank[0] = 0; m_bank[1] = 0;
        end else begin
            if (wdog_rst_i || hw_stby_i) m_err = 0;
            else if (pe_active_i && ((rd_flash_i && !rd_overlap_i) ||
                     (exc_start_i && exc_kind_i >= 4) || sleep_i || bus_rel_i))
                m_err = 1;
            if (wdog_rst_i || hw_stby_i || sw_stby_i || !wen_pin_i || !swe_i) begin
                m_bank[0] = 0; m_bank[1] = 0;
            end else if (wr_i && addr_i == 1) m_bank[0] = wdata_i;
            else if (wr_i && addr_i == 2) m_bank[1] = wdata_i;
        end
    end

    function automatic int ones16(input int v);
        int n = 0;
        for (int i = 0; i < 16; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // Compare every output against the reference.
    task automatic compare();
        int sel, exp_en, exp_rd;
        bit exp_prot, exp_multi;
        sel = (m_bank[1] << 8) | m_bank[0];
        exp_prot = m_err || !wen_pin_i;
        exp_multi = ones16(sel) > 1;
        exp_en = (exp_prot || exp_multi) ? 0 : sel;
        case (addr_i)
            2'd0: exp_rd = m_err ? 8'h80 : 8'h00;
            2'd1: exp_rd = m_bank[0];
            2'd2: exp_rd = m_bank[1];
            default: exp_rd = 0;
        endcase
        check("R9", "protect", protect_o, exp_prot);
        check("R8", "multi_sel", multi_sel_o, exp_multi);
        check("R6", "erase_en", erase_en_o, exp_en);
        check("R1", "rdata", rdata_o, exp_rd);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_i = 1; tick(); wr_i = 0;
    endtask

    task automatic rd_expect(input string tag, input logic [1:0] a, input int exp);
        addr_i = a; #1;
        check(tag, "readback", rdata_o, exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        tick();
        rd_expect("R1", 0, 8'h00);               // reset: flag clear
        check("R6", "reset enables", erase_en_o, 0);

        // R6: single block select and readback
        wen_pin_i = 1; swe_i = 1; tick();
        wr_reg(1, 8'h04);
        check("R6", "bank0 enable", erase_en_o, 16'h0004);
        rd_expect("R6", 1, 8'h04);

        // R8: two bits across both registers
        wr_reg(2, 8'h01);
        check("R8", "violation", multi_sel_o, 1);
        check("R8", "suppressed", erase_en_o, 0);
        wr_reg(1, 8'h00);
        check("R6", "bank1 enable", erase_en_o, 16'h0100);
        wr_reg(1, 8'h30);
        check("R8", "two bits one reg", multi_sel_o, 1);
        wr_reg(1, 8'h00);

        // R2: overlap read and idle read leave flag clear
        pe_active_i = 1; rd_flash_i = 1; rd_overlap_i = 1; tick();
        rd_flash_i = 0; rd_overlap_i = 0;
        rd_expect("R2", 0, 8'h00);
        pe_active_i = 0; rd_flash_i = 1; tick(); rd_flash_i = 0;
        rd_expect("R2", 0, 8'h00);
        pe_active_i = 1; rd_flash_i = 1; tick(); rd_flash_i = 0;
        rd_expect("R2", 0, 8'h80);
        check("R9", "protect on error", protect_o, 1);
        check("R9", "gated enables", erase_en_o, 0);

        // R10: status writes ignored
        wr_reg(0, 8'h00); rd_expect("R10", 0, 8'h80);
        hw_stby_i = 1; tick(); hw_stby_i = 0;
        wr_reg(0, 8'hFF); rd_expect("R10", 0, 8'h00);
        pe_active_i = 1; rd_flash_i = 1; tick(); rd_flash_i = 0;

        // R5: software standby and pin low keep the flag
        sw_stby_i = 1; tick(); sw_stby_i = 0;
        rd_expect("R5", 0, 8'h80);
        wen_pin_i = 0; tick(); wen_pin_i = 1;
        rd_expect("R5", 0, 8'h80);
        wdog_rst_i = 1; sleep_i = 1; tick(); wdog_rst_i = 0; sleep_i = 0;
        rd_expect("R5", 0, 8'h00);               // clear beats set

        // R3: excluded codes, then counted codes
        for (int k = 0; k < 4; k++) begin
            exc_start_i = 1; exc_kind_i = 3'(k); tick();
        end
        exc_start_i = 0;
        rd_expect("R3", 0, 8'h00);
        exc_start_i = 1; exc_kind_i = 3'd4; tick(); exc_start_i = 0;
        rd_expect("R3", 0, 8'h80);
        hw_stby_i = 1; tick(); hw_stby_i = 0;
        exc_start_i = 1; exc_kind_i = 3'd7; tick(); exc_start_i = 0;
        rd_expect("R3", 0, 8'h80);
        rst_n = 0; tick(); rst_n = 1; tick();
        rd_expect("R5", 0, 8'h00);

        // R4: sleep and bus release
        sleep_i = 1; tick(); sleep_i = 0;
        rd_expect("R4", 0, 8'h80);
        hw_stby_i = 1; tick(); hw_stby_i = 0;
        bus_rel_i = 1; tick(); bus_rel_i = 0;
        rd_expect("R4", 0, 8'h80);
        hw_stby_i = 1; tick(); hw_stby_i = 0;
        pe_active_i = 0; sleep_i = 1; bus_rel_i = 1; tick();
        sleep_i = 0; bus_rel_i = 0;
        rd_expect("R4", 0, 8'h00);

        // R7: wipe conditions
        wr_reg(2, 8'h80); rd_expect("R7", 2, 8'h80);
        swe_i = 0; tick(); rd_expect("R7", 2, 8'h00);
        wr_reg(1, 8'h02); rd_expect("R7", 1, 8'h00);
        swe_i = 1; wr_reg(1, 8'h02);
        check("R7", "restored", erase_en_o, 16'h0002);
        wen_pin_i = 0; tick(); wen_pin_i = 1; rd_expect("R7", 1, 8'h00);
        wr_reg(1, 8'h08); sw_stby_i = 1; tick(); sw_stby_i = 0;
        rd_expect("R7", 1, 8'h00);
        wr_reg(2, 8'h08); wdog_rst_i = 1; tick(); wdog_rst_i = 0;
        rd_expect("R7", 2, 8'h00);
        wr_reg(2, 8'h10); hw_stby_i = 1; tick(); hw_stby_i = 0;
        rd_expect("R7", 2, 8'h00);
        rd_expect("R1", 3, 8'h00);
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule